// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes a freshly powered SDRAM array to the point where a memory controller can use it. After reset it holds the command bus deselected for a programmable power-up wait. It then issues a fixed series of commands: one NOP, a precharge of all banks, a run of auto-refresh commands, and a mode-register load. When the last wait has elapsed it declares normal operation and starts the periodic refresh timer. Each gap between commands is counted in clocks, so the next command never arrives early.

A 3-bit phase field tells the rest of the memory subsystem which step is in progress. Three timing bits set CAS latency, row-to-column delay and precharge time, each as 2 or 3 clocks. They are captured once, when the power-up wait ends, and are presented as decoded clock counts for the controller to use in normal operation. A 3-bit interval code selects the periodic refresh rate as a power-of-two multiple of a base period. The base period is a parameter in clocks. Refresh requests are counted, so a request that arrives while another is being acknowledged is kept.

The states are PWRUP, NOP, PRECH, WAIT_RP, REFRESH, WAIT_RC, MODESET, WAIT_MRD and NORMAL. The transitions are:
- PWRUP to NOP when the power-up count expires.
- NOP to PRECH after one clock.
- PRECH to WAIT_RP after one clock.
- WAIT_RP to REFRESH when the precharge gap expires.
- REFRESH to WAIT_RC after one clock.
- WAIT_RC back to REFRESH when the refresh gap expires and refreshes remain.
- WAIT_RC to MODESET when the refresh gap expires and the last refresh has been issued.
- MODESET to WAIT_MRD after one clock.
- WAIT_MRD to NORMAL when its gap expires.
- NORMAL is left only by reset.

Top module: `sdram_init_seq`

## Requirements
- R1: `mode_sel` only ever shows the following values, and never 101, 110 or 111:
  - 000: normal operation.
  - 001: NOP phase, which includes the power-up wait.
  - 010: precharge phase, including its wait.
  - 011: mode-register phase, including its wait.
  - 100: auto-refresh phase, including its waits.
- R2: After reset is released, the command pins {cs_n,ras_n,cas_n,we_n} read 1111 (deselect) for exactly PWRUP_CYCLES clocks. Then a single NOP (0111) is issued.
- R3: On the clock after the NOP, a precharge-all (0010) is issued with address bit 10 set. The first auto-refresh follows exactly 2 clocks later if the precharge-time bit was set, and 3 clocks later if it was clear.
- R4: Exactly NUM_REFRESH auto-refresh commands (0001) are issued, TRC_CYCLES clocks apart. The mode-register load follows TRC_CYCLES clocks after the last one.
- R5: The mode-register load (0000) presents 0x1D0 on address bits [9:0] when the CAS bit is clear, and 0x150 when it is set. This is a CAS latency field in bits [6:4], interleaved burst of four in bits [3:0], all shifted left by 3.
- R6: `init_done` rises exactly MRD_CYCLES (2) clocks after the mode-register load, together with phase 000. It then stays high and rises only once. Reset clears it at once.
- R7: `tim_cas`, `tim_rcd` and `tim_rp` read 2 when the matching configuration bit was set at the end of the power-up wait, and 3 otherwise. They read 3 from reset until that point. Configuration changes after that point have no effect on these outputs, on the mode word or on the precharge gap until the next reset.
- R8: `ref_req` stays low before `init_done`, whatever the interval code.
- R9: With the sequence done, interval code c in 1..5 raises the first `ref_req` exactly CLKS_PER_BASE·2^(c-1) clocks after the code is applied from a disabled state. Codes 0, 6 and 7 raise no request.
- R10: Each clock with `ref_ack` high consumes one pending request. Requests beyond the first accumulate, up to 2^PEND_W-1. A new request in the same clock as an acknowledge leaves the pending count unchanged. An acknowledge with nothing pending does not cancel a request arriving in the same clock.
- R11: In every clock that issues no command, the pins read NOP (0111) and the address is zero. The power-up wait is the only exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl2 | input | 1 | CAS latency: 1 for 2 clocks, 0 for 3 |
| cfg_rcd2 | input | 1 | Row-to-column delay: 1 for 2 clocks, 0 for 3 |
| cfg_rp2 | input | 1 | Precharge time: 1 for 2 clocks, 0 for 3 |
| cfg_ref_code | input | 3 | Periodic refresh interval code |
| ref_ack | input | 1 | Controller acknowledges one refresh request |
| mode_sel | output | 3 | Current command phase |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address lines |
| tim_cas | output | 2 | Latched CAS latency in clocks |
| tim_rcd | output | 2 | Latched row-to-column delay in clocks |
| tim_rp | output | 2 | Latched precharge time in clocks |
| ref_req | output | 1 | Periodic refresh request pending |
| init_done | output | 1 | Normal operation reached |

## Verification
The assertions assume that `ref_ack` is driven only as a single-clock pulse per request. They also assume that `rst_n` changes away from the sampling clock edge. The stimulus changes every input on the falling edge. It acknowledges either in directed one-clock pulses or with a random per-clock probability, and it may acknowledge when nothing is pending, since the block must ignore that. Timing bits and interval codes are drawn at random, including the reserved codes. Both are changed in the middle of the sequence to show that the latched values hold.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [2:0] {
        PH_NORMAL       = 3'b000,
        PH_NOP          = 3'b001,
        PH_PRECHARGE    = 3'b010,
        PH_MODE_SET     = 3'b011,
        PH_AUTO_REFRESH = 3'b100
    } phase_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_NOP,
        ST_PRECH,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_MODESET,
        ST_WAIT_MRD,
        ST_NORMAL
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_INHIBIT   = 4'b1111;
    localparam sd_cmd_t CMD_NOP       = 4'b0111;
    localparam sd_cmd_t CMD_PRECHARGE = 4'b0010;
    localparam sd_cmd_t CMD_REFRESH   = 4'b0001;
    localparam sd_cmd_t CMD_MODE_SET  = 4'b0000;

    typedef struct packed {
        logic cas2;
        logic rcd2;
        logic rp2;
    } tim_cfg_t;

    // Two clocks when the fast bit is set, three otherwise.
    function automatic logic [1:0] clocks_of(input logic fast);
        return fast ? 2'd2 : 2'd3;
    endfunction

    // Mode word: CAS field [6:4], interleaved type [3], burst of four [2:0],
    // shifted left by three to match a 64-bit data path.
    function automatic logic [9:0] mode_word(input logic cas2);
        logic [2:0] cl;
        cl = cas2 ? 3'd2 : 3'd3;
        return {cl, 1'b1, 3'b010, 3'b000};
    endfunction

endpackage

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdinit_cmd_drive.sv
module sdinit_cmd_drive
    import sdinit_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  seq_state_e        state,
    input  logic              cas2,
    output sd_cmd_t           cmd,
    output logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic              done
);

    always_comb begin
        cmd   = CMD_NOP;
        addr  = '0;
        phase = PH_NORMAL;
        done  = 1'b0;
        unique case (state)
            ST_PWRUP: begin
                cmd   = CMD_INHIBIT;
                phase = PH_NOP;
            end
            ST_NOP: begin
                phase = PH_NOP;
            end
            ST_PRECH: begin
                cmd      = CMD_PRECHARGE;
                addr[10] = 1'b1;
                phase    = PH_PRECHARGE;
            end
            ST_WAIT_RP: begin
                phase = PH_PRECHARGE;
            end
            ST_REFRESH: begin
                cmd   = CMD_REFRESH;
                phase = PH_AUTO_REFRESH;
            end
            ST_WAIT_RC: begin
                phase = PH_AUTO_REFRESH;
            end
            ST_MODESET: begin
                cmd       = CMD_MODE_SET;
                addr[9:0] = mode_word(cas2);
                phase     = PH_MODE_SET;
            end
            ST_WAIT_MRD: begin
                phase = PH_MODE_SET;
            end
            ST_NORMAL: begin
                phase = PH_NORMAL;
                done  = 1'b1;
            end
            default: begin
                cmd = CMD_INHIBIT;
            end
        endcase
    end

endmodule

// File: rtl/sdinit_refresh_timer.sv
module sdinit_refresh_timer #(
    parameter int CLKS_PER_BASE = 20,
    parameter int PEND_W        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] code,
    input  logic       ack,
    output logic       req
);

    localparam int MAX_IVAL = CLKS_PER_BASE * 16;
    localparam int CNT_W    = $clog2(MAX_IVAL + 1);

    logic [CNT_W-1:0]  ival;
    logic [CNT_W-1:0]  cnt_q;
    logic [PEND_W-1:0] pend_q;
    logic              enable;
    logic              tick;
    logic              dec;

    always_comb begin
        if (code >= 3'd1 && code <= 3'd5) begin
            ival = CNT_W'(CLKS_PER_BASE) << (code - 3'd1);
        end else begin
            ival = '0;
        end
    end

    assign enable = run && (ival != '0);
    assign tick   = enable && (cnt_q >= ival - CNT_W'(1));
    assign dec    = ack && (pend_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (tick && !dec) begin
            if (pend_q != '1) begin
                pend_q <= pend_q + PEND_W'(1);
            end
        end else if (dec && !tick) begin
            pend_q <= pend_q - PEND_W'(1);
        end
    end

    assign req = (pend_q != '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int PWRUP_CYCLES  = 40,
    parameter int TRC_CYCLES    = 7,
    parameter int NUM_REFRESH   = 8,
    parameter int MRD_CYCLES    = 2,
    parameter int CLKS_PER_BASE = 20,
    parameter int PEND_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cl2,
    input  logic              cfg_rcd2,
    input  logic              cfg_rp2,
    input  logic [2:0]        cfg_ref_code,
    input  logic              ref_ack,
    output logic [2:0]        mode_sel,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [1:0]        tim_cas,
    output logic [1:0]        tim_rcd,
    output logic [1:0]        tim_rp,
    output logic              ref_req,
    output logic              init_done
);

    localparam int MAX_A    = (PWRUP_CYCLES > TRC_CYCLES) ? PWRUP_CYCLES : TRC_CYCLES;
    localparam int WAIT_MAX = (MAX_A > MRD_CYCLES) ? MAX_A : MRD_CYCLES;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam int REF_W    = $clog2(NUM_REFRESH + 1);

    seq_state_e       state_q;
    seq_state_e       state_nx;
    tim_cfg_t         tcfg_q;
    logic [REF_W-1:0] ref_cnt_q;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_expired;
    sd_cmd_t          cmd;
    phase_e           phase;
    logic             done;

    sdinit_gap_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(PWRUP_CYCLES - 1)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .load_val(gap_val),
        .expired (gap_expired)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and wait loading.
    always_comb begin
        state_nx = state_q;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state_q)
            ST_PWRUP: begin
                if (gap_expired) begin
                    state_nx = ST_NOP;
                end
            end
            ST_NOP: begin
                state_nx = ST_PRECH;
            end
            ST_PRECH: begin
                gap_load = 1'b1;
                gap_val  = tcfg_q.rp2 ? CNT_W'(0) : CNT_W'(1);
                state_nx = ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                if (gap_expired) begin
                    state_nx = ST_REFRESH;
                end
            end
            ST_REFRESH: begin
                gap_load = 1'b1;
                gap_val  = CNT_W'(TRC_CYCLES - 2);
                state_nx = ST_WAIT_RC;
            end
            ST_WAIT_RC: begin
                if (gap_expired) begin
                    if (ref_cnt_q == REF_W'(NUM_REFRESH)) begin
                        state_nx = ST_MODESET;
                    end else begin
                        state_nx = ST_REFRESH;
                    end
                end
            end
            ST_MODESET: begin
                gap_load = 1'b1;
                gap_val  = CNT_W'(MRD_CYCLES - 2);
                state_nx = ST_WAIT_MRD;
            end
            ST_WAIT_MRD: begin
                if (gap_expired) begin
                    state_nx = ST_NORMAL;
                end
            end
            ST_NORMAL: begin
                state_nx = ST_NORMAL;
            end
            default: begin
                state_nx = ST_PWRUP;
            end
        endcase
    end

    // Refresh count and timing capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            tcfg_q    <= '0;
        end else begin
            if (state_q == ST_REFRESH) begin
                ref_cnt_q <= ref_cnt_q + REF_W'(1);
            end
            if (state_q == ST_PWRUP && gap_expired) begin
                tcfg_q <= '{cas2: cfg_cl2, rcd2: cfg_rcd2, rp2: cfg_rp2};
            end
        end
    end

    // Output decode.
    sdinit_cmd_drive #(
        .ADDR_W(ADDR_W)
    ) u_drive (
        .state(state_q),
        .cas2 (tcfg_q.cas2),
        .cmd  (cmd),
        .addr (cmd_addr),
        .phase(phase),
        .done (done)
    );

    sdinit_refresh_timer #(
        .CLKS_PER_BASE(CLKS_PER_BASE),
        .PEND_W       (PEND_W)
    ) u_refresh (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (done),
        .code (cfg_ref_code),
        .ack  (ref_ack),
        .req  (ref_req)
    );

    assign mode_sel  = phase;
    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign init_done = done;
    assign tim_cas   = clocks_of(tcfg_q.cas2);
    assign tim_rcd   = clocks_of(tcfg_q.rcd2);
    assign tim_rp    = clocks_of(tcfg_q.rp2);

endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_ack,
    input logic [2:0]        mode_sel,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [1:0]        tim_cas,
    input logic [1:0]        tim_rcd,
    input logic [1:0]        tim_rp,
    input logic              ref_req,
    input logic              init_done
);

    logic [3:0] pins;
    logic       seen_done;

    assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_done <= 1'b0;
        end else if (init_done) begin
            seen_done <= 1'b1;
        end
    end

    p_phase_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel <= 3'd4);

    p_pre_after_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> ($past(pins) == 4'b0111 && cmd_addr[10] && mode_sel == 3'b010));

    p_refresh_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0001) |-> (mode_sel == 3'b100 && !init_done));

    p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (cmd_addr[9:0] == ((tim_cas == 2'd2) ? 10'h150 : 10'h1D0)));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> !seen_done);

    p_timing_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> ($stable(tim_cas) && $stable(tim_rcd) && $stable(tim_rp)));

    p_no_req_in_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    p_req_fall_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> $past(ref_ack));

    p_idle_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0111) |-> (cmd_addr == '0));

endmodule

bind sdram_init_seq sdinit_checker #(.ADDR_W(ADDR_W)) u_sdinit_checker (.*);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int AW    = 13;
    localparam int P     = 40;
    localparam int TRC   = 7;
    localparam int NREF  = 8;
    localparam int MRD   = 2;
    localparam int BASE  = 20;
    localparam int PMAX  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_cl2 = 1'b0, cfg_rcd2 = 1'b0, cfg_rp2 = 1'b0;
    logic [2:0]    cfg_ref_code = 3'd0;
    logic          ref_ack = 1'b0;
    logic [2:0]    mode_sel;
    logic          cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [AW-1:0] cmd_addr;
    logic [1:0]    tim_cas, tim_rcd, tim_rp;
    logic          ref_req, init_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(AW), .PWRUP_CYCLES(P), .TRC_CYCLES(TRC), .NUM_REFRESH(NREF),
        .MRD_CYCLES(MRD), .CLKS_PER_BASE(BASE), .PEND_W(2)
    ) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .cfg_cl2(cfg_cl2), .cfg_rcd2(cfg_rcd2),
        .cfg_rp2(cfg_rp2), .cfg_ref_code(cfg_ref_code), .ref_ack(ref_ack),
        .mode_sel(mode_sel), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr),
        .tim_cas(tim_cas), .tim_rcd(tim_rcd), .tim_rp(tim_rp),
        .ref_req(ref_req), .init_done(init_done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clk_of(input bit fast);
        return fast ? 2 : 3;
    endfunction

    function automatic int exp_word(input bit cas2);
        return cas2 ? 'h150 : 'h1D0;
    endfunction

    function automatic int ival_of(input int code);
        return (code >= 1 && code <= 5) ? (BASE << (code - 1)) : 0;
    endfunction

    task automatic run_init(input bit cl, input bit rcd, input bit rp, input bit flip, input bit chk_reset);
        int first_nop = -1, last_inh = -1, pre_k = -1, mrs_k = -1, done_k = -1;
        int ref_k[16];
        int nref = 0;
        int bad_phase = 0, bad_req = 0, bad_idle = 0, bad_word = 0, bad_gap = 0;
        logic [3:0] pins;
        cfg_cl2 = cl; cfg_rcd2 = rcd; cfg_rp2 = rp;
        cfg_ref_code = 3'($urandom_range(1, 7));
        ref_ack = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        if (chk_reset) begin
            pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
            check(pins == 4'b1111, "R2 reset pins", pins, 4'b1111);
            check(mode_sel == 3'b001, "R1 reset phase", mode_sel, 1);
            check(!init_done, "R6 reset done", init_done, 0);
            check(!ref_req, "R8 reset req", ref_req, 0);
            check(tim_cas == 3 && tim_rcd == 3 && tim_rp == 3, "R7 reset timing",
                  {tim_cas, tim_rcd, tim_rp}, 6'b111111);
        end
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
            if (mode_sel > 3'd4) bad_phase++;
            if (!init_done && ref_req) bad_req++;
            if (pins == 4'b1111) last_inh = k;
            if (pins == 4'b0111) begin
                if (cmd_addr != '0) bad_idle++;
                if (first_nop < 0) first_nop = k;
            end
            if (pins == 4'b0010) begin
                pre_k = k;
                if (!cmd_addr[10] || mode_sel != 3'b010) bad_phase++;
            end
            if (pins == 4'b0001) begin
                if (nref < 16) ref_k[nref] = k;
                nref++;
                if (mode_sel != 3'b100) bad_phase++;
            end
            if (pins == 4'b0000) begin
                mrs_k = k;
                if (int'(cmd_addr) != exp_word(cl)) bad_word++;
                if (mode_sel != 3'b011) bad_phase++;
            end
            if (init_done && done_k < 0) begin
                done_k = k;
                if (mode_sel != 3'b000) bad_phase++;
            end
            if (flip && k == P + 1) begin
                cfg_cl2 = ~cl; cfg_rcd2 = ~rcd; cfg_rp2 = ~rp;
                cfg_ref_code = 3'($urandom_range(1, 7));
            end
            if (done_k >= 0 && k > done_k + 3) break;
        end
        check(first_nop == P, "R2 first NOP cycle", first_nop, P);
        check(last_inh == P - 1, "R2 last deselect cycle", last_inh, P - 1);
        check(pre_k == P + 1, "R3 precharge cycle", pre_k, P + 1);
        check(nref >= 1 && ref_k[0] == P + 1 + clk_of(rp), "R3 first refresh cycle",
              (nref >= 1) ? ref_k[0] : -1, P + 1 + clk_of(rp));
        check(nref == NREF, "R4 refresh count", nref, NREF);
        for (int i = 1; i < NREF && i < nref; i++)
            if (ref_k[i] - ref_k[i-1] != TRC) bad_gap++;
        check(bad_gap == 0, "R4 refresh spacing errors", bad_gap, 0);
        check(nref == NREF && mrs_k == ref_k[NREF-1] + TRC, "R4 mode load cycle",
              mrs_k, P + 1 + clk_of(rp) + NREF * TRC);
        check(bad_word == 0 && mrs_k > 0, "R5 mode word", bad_word, 0);
        check(done_k == mrs_k + MRD, "R6 done cycle", done_k, mrs_k + MRD);
        check(tim_cas == clk_of(cl), "R7 tim_cas latched", tim_cas, clk_of(cl));
        check(tim_rcd == clk_of(rcd), "R7 tim_rcd latched", tim_rcd, clk_of(rcd));
        check(tim_rp == clk_of(rp), "R7 tim_rp latched", tim_rp, clk_of(rp));
        check(bad_req == 0, "R8 request during init", bad_req, 0);
        check(bad_phase == 0, "R1 phase values", bad_phase, 0);
        check(bad_idle == 0, "R11 idle address", bad_idle, 0);
    endtask

    task automatic drain();
        cfg_ref_code = 3'd0;
        for (int i = 0; i < 8; i++) begin
            ref_ack = ref_req;
            @(negedge clk);
        end
        ref_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure(input int code);
        int n = 0;
        int lim;
        drain();
        cfg_ref_code = 3'(code);
        lim = (ival_of(code) == 0) ? 2 * BASE * 16 + 10 : ival_of(code) + 50;
        while (n < lim) begin
            @(negedge clk);
            n++;
            if (ref_req) break;
        end
        if (ival_of(code) == 0)
            check(!ref_req, "R9 disabled code raised request", ref_req, 0);
        else
            check(ref_req && n == ival_of(code), "R9 first request delay", n, ival_of(code));
    endtask

    task automatic step(input bit a);
        ref_ack = a;
        @(negedge clk);
    endtask

    initial begin
        int pm;
        int iv;
        bit a, tick;
        void'($urandom(32'd20240611));
        run_init(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        run_init(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int r = 0; r < 4; r++)
            run_init(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);

        // R6: reset clears done at once
        @(negedge clk) rst_n = 1'b0;
        #1;
        check(!init_done, "R6 done cleared by reset", init_done, 0);
        run_init(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: intervals per code
        for (int c = 1; c <= 5; c++) measure(c);
        measure(0);
        measure(6);
        measure(7);

        // R10: directed accumulation and coincidence, code 1
        drain();
        cfg_ref_code = 3'd1;
        repeat (40) step(1'b0);
        check(ref_req, "R10 two pending", ref_req, 1);
        step(1'b1);
        check(ref_req, "R10 one left after ack", ref_req, 1);
        step(1'b1);
        check(!ref_req, "R10 empty after second ack", ref_req, 0);
        step(1'b0);
        repeat (16) step(1'b0);
        step(1'b1);
        check(ref_req, "R10 empty ack with new request", ref_req, 1);
        repeat (19) step(1'b0);
        step(1'b1);
        check(ref_req, "R10 ack coinciding with request", ref_req, 1);
        step(1'b1);
        check(!ref_req, "R10 cleared after last ack", ref_req, 0);
        repeat (99) step(1'b0);
        step(1'b1);
        step(1'b1);
        check(ref_req, "R10 saturated count after two acks", ref_req, 1);
        step(1'b1);
        check(!ref_req, "R10 saturated count after three acks", ref_req, 0);
        ref_ack = 1'b0;

        // R10: random acknowledges against a pending-count model, code 2
        drain();
        cfg_ref_code = 3'd2;
        iv = ival_of(2);
        pm = 0;
        for (int n = 0; n < 400; n++) begin
            a = ($urandom_range(0, 2) == 0);
            ref_ack = a;
            @(negedge clk);
            tick = ((n + 1) % iv == 0);
            if (tick && !(a && pm != 0)) begin
                if (pm < PMAX) pm++;
            end else if (!tick && a && pm != 0) begin
                pm--;
            end
            check(ref_req == (pm != 0), "R10 random acknowledge", ref_req, pm != 0);
        end
        ref_ack = 1'b0;
        check(init_done, "R6 done still high", init_done, 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule